// File: doc/BRIEF.md
# Edge-and-Refresh Pulse Level Link

This block carries one logic level across a channel that can only carry short pulses. The sending half watches its input and emits a one-cycle "set" pulse when the input rises and a one-cycle "clear" pulse when it falls. While the input is unchanged, it repeats the current level as a refresh pulse at a fixed interval, so a receiver that lost or misread a pulse is corrected within one interval.

The receiving half is a set/clear state holder. A valid pulse loads the level it encodes and enables the output. A watchdog counts cycles without any valid pulse. When the count reaches its timeout, the receiver judges the sender dead and turns its output enable off, which places the output in high impedance. Both halves run on one clock. The channel is brought out at the top so that it can be routed, broken or disturbed between the two halves.

Top module: `level_pulse_link`

## Requirements
- R1: A rising level_i, seen at a clock edge, produces exactly one cycle of tx_set_o starting just after that edge.
- R2: A falling level_i, seen at a clock edge, produces exactly one cycle of tx_clr_o starting just after that edge.
- R3: If level_i has not changed for REFRESH_CYC cycles, a refresh pulse is sent on tx_set_o when the level is 1 or on tx_clr_o when it is 0. The refresh repeats every REFRESH_CYC cycles while the level is held.
- R4: Every input transition restarts the refresh interval. tx_set_o and tx_clr_o are never high together, and an edge and a refresh never produce two pulses in one cycle.
- R5: A cycle with rx_set_i=1 and rx_clr_i=0 drives rx_data_o to 1 on the next cycle. A cycle with rx_clr_i=1 and rx_set_i=0 drives it to 0. Between valid pulses rx_data_o holds its value.
- R6: If no valid pulse arrives for WDOG_CYC consecutive cycles, rx_oe_o drops to 0 exactly WDOG_CYC cycles after the edge that captured the last pulse. rx_data_o keeps its last value.
- R7: Any valid pulse restarts the watchdog and sets rx_oe_o to 1 on the next cycle.
- R8: While rst_ni is low, tx_set_o, tx_clr_o, rx_data_o and rx_oe_o are all 0. rx_oe_o stays 0 until the first valid pulse.
- R9: A cycle with rx_set_i and rx_clr_i both high is not a valid pulse. It changes neither rx_data_o nor rx_oe_o and does not restart the watchdog.
- R10: With WDOG_CYC greater than REFRESH_CYC, a connected, idle link keeps rx_oe_o at 1 indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both halves |
| rst_ni | input | 1 | Active-low asynchronous reset |
| level_i | input | 1 | Level to be carried |
| tx_set_o | output | 1 | Channel pulse: level is 1 |
| tx_clr_o | output | 1 | Channel pulse: level is 0 |
| rx_set_i | input | 1 | Received set pulse |
| rx_clr_i | input | 1 | Received clear pulse |
| rx_data_o | output | 1 | Recovered level |
| rx_oe_o | output | 1 | Output enable; 0 means high impedance |

## Verification
The hardest situations to reach are a receiver that disagrees with the sender, and a receiver that hears nothing. A healthy loop never produces either. The bench therefore sits between tx and rx. It can silence the channel, and the reference model then predicts the exact cycle in which the output enable falls. It can also inject a lone clear pulse, or a set and clear together, shortly after an input edge. That timing keeps the injection clear of any refresh, so the wrong level stays visible until the next refresh repairs it.

// File: rtl/pl_pkg.sv
package pl_pkg;
  typedef enum logic [1:0] {
    PL_IDLE = 2'b00,
    PL_SET  = 2'b01,
    PL_CLR  = 2'b10,
    PL_BAD  = 2'b11
  } pl_code_e;

  function automatic pl_code_e pl_decode(input logic set_p, input logic clr_p);
    return pl_code_e'({clr_p, set_p});
  endfunction
endpackage

// File: rtl/pl_tx.sv
module pl_tx
  import pl_pkg::*;
#(
  parameter int REFRESH_CYC = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic set_o,
  output logic clr_o
);
  localparam int CW = $clog2(REFRESH_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(REFRESH_CYC - 1);

  logic          prev_q;
  logic [CW-1:0] idle_q;
  logic          edge_w, fire_w;
  pl_code_e      code_d;

  assign edge_w = level_i ^ prev_q;
  assign fire_w = !edge_w && (idle_q == LAST);

  always_comb begin
    code_d = PL_IDLE;
    if (edge_w || fire_w) code_d = level_i ? PL_SET : PL_CLR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      idle_q <= '0;
      set_o  <= 1'b0;
      clr_o  <= 1'b0;
    end else begin
      prev_q <= level_i;
      // interval restarts on a real transition or after a refresh
      if (edge_w || fire_w) idle_q <= '0;
      else                  idle_q <= idle_q + 1'b1;
      set_o  <= (code_d == PL_SET);
      clr_o  <= (code_d == PL_CLR);
    end
  end

  // R1
  rise_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i && !prev_q) |=> set_o);
  // R2
  fall_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && prev_q) |=> clr_o);
  // R3
  set_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |-> prev_q);
  // R3
  clr_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> !prev_q);
  // R4
  one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_o, clr_o}));
endmodule

// File: rtl/pl_wdog.sv
module pl_wdog #(
  parameter int WDOG_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expired_o
);
  localparam int CW = $clog2(WDOG_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WDOG_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      expired_o <= 1'b1;
    end else if (kick_i) begin
      cnt_q     <= '0;
      expired_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      expired_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7
  kick_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !expired_o);
endmodule

// File: rtl/pl_rx.sv
module pl_rx
  import pl_pkg::*;
#(
  parameter int WDOG_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic data_o,
  output logic oe_o
);
  pl_code_e code_w;
  logic     valid_w, expired_w;

  assign code_w  = pl_decode(set_i, clr_i);
  assign valid_w = (code_w == PL_SET) || (code_w == PL_CLR);

  pl_wdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kick_i    (valid_w),
    .expired_o (expired_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= 1'b0;
    else if (valid_w) data_o <= (code_w == PL_SET);
  end

  assign oe_o = !expired_w;

  // R5
  set_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> (data_o && oe_o));
  // R5
  clr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> (!data_o && oe_o));
  // R9
  both_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> $stable(data_o));
  // R6
  drop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> !$past(set_i ^ clr_i));
endmodule

// File: rtl/level_pulse_link.sv
module level_pulse_link #(
  parameter int REFRESH_CYC = 60,
  parameter int WDOG_CYC    = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic tx_set_o,
  output logic tx_clr_o,
  input  logic rx_set_i,
  input  logic rx_clr_i,
  output logic rx_data_o,
  output logic rx_oe_o
);
  pl_tx #(.REFRESH_CYC(REFRESH_CYC)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level_i),
    .set_o   (tx_set_o),
    .clr_o   (tx_clr_o)
  );

  pl_rx #(.WDOG_CYC(WDOG_CYC)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (rx_set_i),
    .clr_i  (rx_clr_i),
    .data_o (rx_data_o),
    .oe_o   (rx_oe_o)
  );
endmodule

// File: tb/sim_level_pulse_link.sv
`timescale 1ns/1ps
module sim_level_pulse_link;
  localparam int RC = 60;
  localparam int WC = 250;

  logic clk = 1'b0, rst_n = 1'b0, lvl = 1'b0;
  logic kill = 1'b0, inj_s = 1'b0, inj_c = 1'b0;
  logic tx_s, tx_c, rx_d, rx_oe, ch_s, ch_c;
  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign ch_s = (tx_s & ~kill) | inj_s;
  assign ch_c = (tx_c & ~kill) | inj_c;

  level_pulse_link #(.REFRESH_CYC(RC), .WDOG_CYC(WC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .level_i(lvl),
    .tx_set_o(tx_s), .tx_clr_o(tx_c),
    .rx_set_i(ch_s), .rx_clr_i(ch_c),
    .rx_data_o(rx_d), .rx_oe_o(rx_oe)
  );

  // behavioural reference
  bit m_prev, m_set, m_clr, m_data, m_oe;
  int m_idle, m_wd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_set = 0; m_clr = 0; m_data = 0; m_oe = 0;
      m_idle = 0; m_wd = 0;
    end else begin
      bit chg, ref_due, s, c;
      s = ch_s; c = ch_c;
      chg = (lvl != m_prev);
      ref_due = !chg && (m_idle == RC - 1);
      m_set = (chg || ref_due) && lvl;
      m_clr = (chg || ref_due) && !lvl;
      m_idle = (chg || ref_due) ? 0 : m_idle + 1;
      m_prev = lvl;
      if (s != c) begin
        m_data = s; m_oe = 1; m_wd = 0;
      end else if (m_wd == WC - 1) m_oe = 0;
      else m_wd++;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R1 R3 R4 tx_set", tx_s, m_set);
    chk("R2 R3 R4 tx_clr", tx_c, m_clr);
    chk("R5 R9 rx_data", rx_d, m_data);
    chk("R6 R7 rx_oe", rx_oe, m_oe);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    step(3);
    chk("R8 reset tx_set", tx_s, 0);
    chk("R8 reset tx_clr", tx_c, 0);
    chk("R8 reset data", rx_d, 0);
    chk("R8 reset oe", rx_oe, 0);
    rst_n = 1;
    step(RC + 5);
    chk("R3 first refresh oe", rx_oe, 1);
    chk("R3 first refresh data", rx_d, 0);
    lvl = 1; step(3);
    chk("R1 rise data", rx_d, 1);
    step(3 * RC);
    chk("R10 idle oe", rx_oe, 1);
    chk("R10 idle data", rx_d, 1);
    lvl = 0; step(3);
    chk("R2 fall data", rx_d, 0);
    // spurious clear right after an edge, well before refresh
    lvl = 1; step(3);
    inj_c = 1; step(1); inj_c = 0; step(2);
    chk("R5 spurious clr data", rx_d, 0);
    step(RC);
    chk("R3 refresh restores data", rx_d, 1);
    // both lines together while data is 0
    lvl = 0; step(3);
    inj_s = 1; inj_c = 1; step(1); inj_s = 0; inj_c = 0; step(2);
    chk("R9 both ignored data", rx_d, 0);
    chk("R9 both ignored oe", rx_oe, 1);
    for (int i = 0; i < 12; i++) begin
      lvl = ~lvl; step(2);
    end
    step(4);
    chk("R4 toggles end level", rx_d, lvl);
    kill = 1; step(WC + RC + 2);
    chk("R6 silent oe", rx_oe, 0);
    chk("R6 silent data held", rx_d, lvl);
    kill = 0; step(RC + 3);
    chk("R7 reenable oe", rx_oe, 1);
    rst_n = 0; step(2);
    chk("R8 mid reset oe", rx_oe, 0);
    chk("R8 mid reset data", rx_d, 0);
    rst_n = 1; step(5);
    chk("R8 oe stays low before pulse", rx_oe, 0);
    finish_run();
  end
endmodule